// File: doc/BRIEF.md
# 16-bit Pointer and Stack Address Arithmetic Unit

This purely combinational unit produces the 16-bit values that an 8-bit processor core needs for pointer updates, stack pointer adjustment, fixed-page I/O addressing and relative branches. An operation code chooses what is computed. The result appears on `res_o`, the memory address to use appears on `addr_o`, and the updated condition flags appear on `flags_o`. Every sum goes through one shared ripple-carry adder. The carry taps of that adder supply the half-carry and carry flags.

The unit has no clock and no state. The core's sequencer drives the operands, picks the operation, and in the same cycle writes `res_o` to the destination the operation implies. That destination is the pointer for codes 0, 2, 5 and 6, the stack pointer for code 1, the addressed pair for codes 3 and 4, and the program counter for code 9. The unit carries no data stream, so it has no valid/ready handshake and applies no back-pressure: an output is valid as soon as its inputs settle. Condition testing and memory sequencing belong to the caller.

Top module: `asu_addr_unit`

## Requirements
- R1: Op code 0 (pointer add) returns `res_o = ptr_i + opnd_i` modulo 65536.
- R2: For op code 0, `flags_o` keeps Z (bit 3) from `flags_i`, clears N (bit 2), sets H (bit 1) on a carry out of bit 11 and sets C (bit 0) on a carry out of bit 15. The flag nibble is laid out {Z,N,H,C} on bits 3..0 on both the input and the output.
- R3: Op codes 1 (stack offset, in place) and 2 (stack offset, redirected to the pointer) both return `sp_i` plus `imm_i` sign-extended, modulo 65536. The two codes give identical outputs.
- R4: For op codes 1 and 2, Z and N are cleared. H and C are the carries out of bits 3 and 7 of the unsigned add `sp_i[7:0] + imm_i`, whatever the sign of the offset.
- R5: Op code 3 returns `opnd_i + 1` and op code 4 returns `opnd_i - 1`, both wrapping modulo 65536.
- R6: Op codes 5 (post-increment) and 6 (post-decrement) drive `addr_o = ptr_i`. They return `res_o = ptr_i + 1` and `ptr_i - 1` respectively, with wrap.
- R7: Op code 7 returns 0xFF00 plus `imm_i`. Op code 8 returns 0xFF00 plus `reg_c_i`.
- R8: Op code 9 returns `pc_i + 2 +` the sign-extended `imm_i`, modulo 65536, where `pc_i` is the address of the 2-byte branch.
- R9: Op codes 10 to 15 return zero on both `res_o` and `addr_o`.
- R10: Every op code other than 0, 1 and 2 returns `flags_o` equal to `flags_i`.
- R11: For every op code except 5 and 6, `addr_o` equals `res_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (0..9 defined, 10..15 unused) |
| ptr_i | input | 16 | Current pointer register value |
| sp_i | input | 16 | Current stack pointer |
| pc_i | input | 16 | Address of the branch instruction |
| opnd_i | input | 16 | 16-bit operand (addend or pair to step) |
| imm_i | input | 8 | Immediate byte, signed offset or page offset |
| reg_c_i | input | 8 | Register byte used as page offset |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| res_o | output | 16 | Computed 16-bit result |
| addr_o | output | 16 | Memory address for the operation |
| flags_o | output | 4 | Updated flags {Z,N,H,C} |

## Verification
The bound checker evaluates the following whenever the inputs change:
- the post-step address equals the incoming pointer;
- flags pass through untouched for codes 3 to 15;
- the fixed Z/N values for pointer and stack additions;
- the page bits on codes 7 and 8;
- zero output for unused codes;
- `addr_o` matches `res_o` outside the post-step codes.

Only the bench sweeps can show that the sums wrap correctly. The same holds for H and C coming from the right carry positions (11/15 against 3/7) and for negative offsets giving unsigned low-byte carries. The bench covers these with full 256-value offset sweeps against arithmetically computed results.

// File: rtl/asu_pkg.sv
package asu_pkg;

  typedef enum logic [3:0] {
    OP_ADD_PTR     = 4'd0,
    OP_SP_OFS      = 4'd1,
    OP_SP_OFS_PTR  = 4'd2,
    OP_STEP_UP     = 4'd3,
    OP_STEP_DN     = 4'd4,
    OP_PTR_POSTINC = 4'd5,
    OP_PTR_POSTDEC = 4'd6,
    OP_PAGE_IMM    = 4'd7,
    OP_PAGE_REG    = 4'd8,
    OP_BRANCH      = 4'd9
  } asu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } asu_flags_t;

endpackage

// File: rtl/asu_ripple_add.sv
// Ripple-carry adder that exposes the carry out of four chosen bit positions.
module asu_ripple_add #(
  parameter int W     = 16,
  parameter int OFS_W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic [3:0]   tap_o
);
  localparam int NH = OFS_W / 2 - 1;
  localparam int NC = OFS_W - 1;
  localparam int WH = W - 5;
  localparam int WC = W - 1;

  logic [W:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
    assign cy[i+1]  = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
  end

  assign tap_o = {cy[WC+1], cy[WH+1], cy[NC+1], cy[NH+1]};
endmodule

// File: rtl/asu_operand_sel.sv
// Picks the two adder operands for the selected operation.
module asu_operand_sel import asu_pkg::*; #(
  parameter int W      = 16,
  parameter int OFS_W  = 8,
  parameter int BR_LEN = 2
) (
  input  logic [3:0]       op_i,
  input  logic [W-1:0]     ptr_i,
  input  logic [W-1:0]     sp_i,
  input  logic [W-1:0]     pc_i,
  input  logic [W-1:0]     opnd_i,
  input  logic [OFS_W-1:0] imm_i,
  output logic [W-1:0]     a_o,
  output logic [W-1:0]     b_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] MONE = '1;
  localparam logic [W-1:0] SKIP = W'(BR_LEN);

  logic [W-1:0] ofs_sx;
  logic [W-1:0] pc_next;

  assign ofs_sx  = {{(W-OFS_W){imm_i[OFS_W-1]}}, imm_i};
  assign pc_next = pc_i + SKIP;

  always_comb begin
    a_o = '0;
    b_o = '0;
    unique case (asu_op_e'(op_i))
      OP_ADD_PTR:     begin a_o = ptr_i;   b_o = opnd_i; end
      OP_SP_OFS,
      OP_SP_OFS_PTR:  begin a_o = sp_i;    b_o = ofs_sx; end
      OP_STEP_UP:     begin a_o = opnd_i;  b_o = ONE;    end
      OP_STEP_DN:     begin a_o = opnd_i;  b_o = MONE;   end
      OP_PTR_POSTINC: begin a_o = ptr_i;   b_o = ONE;    end
      OP_PTR_POSTDEC: begin a_o = ptr_i;   b_o = MONE;   end
      OP_BRANCH:      begin a_o = pc_next; b_o = ofs_sx; end
      default:        begin a_o = '0;      b_o = '0;     end
    endcase
  end
endmodule

// File: rtl/asu_flag_gen.sv
// Forms the outgoing flags from the adder carry taps.
module asu_flag_gen import asu_pkg::*; (
  input  logic [3:0] op_i,
  input  logic [3:0] tap_i,
  input  logic [3:0] flags_i,
  output logic [3:0] flags_o
);
  asu_flags_t fin;
  asu_flags_t fout;

  assign fin = asu_flags_t'(flags_i);

  always_comb begin
    fout = fin;
    unique case (asu_op_e'(op_i))
      OP_ADD_PTR: begin
        fout.z = fin.z;
        fout.n = 1'b0;
        fout.h = tap_i[2];
        fout.c = tap_i[3];
      end
      OP_SP_OFS, OP_SP_OFS_PTR: begin
        fout.z = 1'b0;
        fout.n = 1'b0;
        fout.h = tap_i[0];
        fout.c = tap_i[1];
      end
      default: fout = fin;
    endcase
  end

  assign flags_o = fout;
endmodule

// File: rtl/asu_addr_unit.sv
module asu_addr_unit import asu_pkg::*; #(
  parameter int W      = 16,
  parameter int OFS_W  = 8,
  parameter int BR_LEN = 2,
  parameter logic [W-1:0] PAGE_BASE = {{(W-OFS_W){1'b1}}, {OFS_W{1'b0}}}
) (
  input  logic [3:0]       op_i,
  input  logic [W-1:0]     ptr_i,
  input  logic [W-1:0]     sp_i,
  input  logic [W-1:0]     pc_i,
  input  logic [W-1:0]     opnd_i,
  input  logic [OFS_W-1:0] imm_i,
  input  logic [OFS_W-1:0] reg_c_i,
  input  logic [3:0]       flags_i,
  output logic [W-1:0]     res_o,
  output logic [W-1:0]     addr_o,
  output logic [3:0]       flags_o
);
  logic [W-1:0] add_a;
  logic [W-1:0] add_b;
  logic [W-1:0] add_sum;
  logic [3:0]   taps;

  asu_operand_sel #(.W(W), .OFS_W(OFS_W), .BR_LEN(BR_LEN)) u_sel (
    .op_i   (op_i),
    .ptr_i  (ptr_i),
    .sp_i   (sp_i),
    .pc_i   (pc_i),
    .opnd_i (opnd_i),
    .imm_i  (imm_i),
    .a_o    (add_a),
    .b_o    (add_b)
  );

  asu_ripple_add #(.W(W), .OFS_W(OFS_W)) u_add (
    .a_i   (add_a),
    .b_i   (add_b),
    .sum_o (add_sum),
    .tap_o (taps)
  );

  asu_flag_gen u_flg (
    .op_i    (op_i),
    .tap_i   (taps),
    .flags_i (flags_i),
    .flags_o (flags_o)
  );

  // Fixed-page offset is OR-ed in: PAGE_BASE low byte is zero.
  always_comb begin
    unique case (asu_op_e'(op_i))
      OP_PAGE_IMM: res_o = PAGE_BASE | {{(W-OFS_W){1'b0}}, imm_i};
      OP_PAGE_REG: res_o = PAGE_BASE | {{(W-OFS_W){1'b0}}, reg_c_i};
      OP_ADD_PTR, OP_SP_OFS, OP_SP_OFS_PTR, OP_STEP_UP, OP_STEP_DN,
      OP_PTR_POSTINC, OP_PTR_POSTDEC, OP_BRANCH: res_o = add_sum;
      default:     res_o = '0;
    endcase
  end

  assign addr_o = (op_i == OP_PTR_POSTINC || op_i == OP_PTR_POSTDEC) ? ptr_i : res_o;
endmodule

// File: rtl/asu_addr_unit_chk.sv
module asu_addr_unit_chk #(
  parameter int W = 16,
  parameter logic [W-1:0] PAGE_BASE = 16'hFF00
) (
  input logic [3:0]   op_i,
  input logic [W-1:0] ptr_i,
  input logic [3:0]   flags_i,
  input logic [W-1:0] res_o,
  input logic [W-1:0] addr_o,
  input logic [3:0]   flags_o
);
  always_comb begin
    if (!$isunknown({op_i, ptr_i, flags_i, res_o, addr_o, flags_o})) begin
      // R6
      post_addr_chk: assert (!(op_i == 4'd5 || op_i == 4'd6) || addr_o == ptr_i)
        else $error("post-step address differs from pointer");
      // R10
      flag_pass_chk: assert (op_i < 4'd3 || flags_o == flags_i)
        else $error("flags altered by a non-arithmetic op");
      // R4
      sp_zn_chk: assert (!(op_i == 4'd1 || op_i == 4'd2) || flags_o[3:2] == 2'b00)
        else $error("stack offset add left Z or N set");
      // R2
      ptr_zn_chk: assert (op_i != 4'd0 || (flags_o[3] == flags_i[3] && !flags_o[2]))
        else $error("pointer add changed Z or set N");
      // R7
      page_bits_chk: assert (!(op_i == 4'd7 || op_i == 4'd8) || (res_o & PAGE_BASE) == PAGE_BASE)
        else $error("page address lost its page bits");
      // R9
      unused_zero_chk: assert (op_i < 4'd10 || (res_o == '0 && addr_o == '0))
        else $error("unused op produced nonzero output");
      // R11
      addr_follow_chk: assert (op_i == 4'd5 || op_i == 4'd6 || addr_o == res_o)
        else $error("address differs from result");
    end
  end
endmodule

bind asu_addr_unit asu_addr_unit_chk #(.W(W), .PAGE_BASE(PAGE_BASE)) u_chk (.*);

// File: tb/sim_asu_addr_unit.sv
`timescale 1ns/1ps
module sim_asu_addr_unit;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op;
  logic [15:0] ptr, sp, pc, opnd;
  logic [7:0]  imm, regc;
  logic [3:0]  fin;
  logic [15:0] res, addr;
  logic [3:0]  fout;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  asu_addr_unit u0 (
    .op_i(op), .ptr_i(ptr), .sp_i(sp), .pc_i(pc), .opnd_i(opnd),
    .imm_i(imm), .reg_c_i(regc), .flags_i(fin),
    .res_o(res), .addr_o(addr), .flags_o(fout)
  );

  logic [15:0] pats [16] = '{16'h0000, 16'h0001, 16'h000F, 16'h0010,
                             16'h00FF, 16'h0100, 16'h07FF, 16'h0800,
                             16'h0FFF, 16'h1000, 16'h7FFF, 16'h8000,
                             16'hC0DE, 16'hF00F, 16'hFFFE, 16'hFFFF};

  function automatic logic [15:0] sx(input logic [7:0] v);
    return {{8{v[7]}}, v};
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%0d got=%h exp=%h", tag, op, got, exp);
    end
  endtask

  // Drive one vector, compute expectations from the requirements, compare.
  task automatic run(input logic [3:0] o, input logic [15:0] p, input logic [15:0] s,
                     input logic [15:0] c, input logic [15:0] d, input logic [7:0] i,
                     input logic [7:0] r, input logic [3:0] f);
    logic [16:0] wide;
    logic [15:0] er, ea;
    logic [3:0]  ef;
    logic        h, cy;
    op = o; ptr = p; sp = s; pc = c; opnd = d; imm = i; regc = r; fin = f;
    ef = f;
    case (o)
      4'd0: begin
        wide = {1'b0, p} + {1'b0, d};
        er = wide[15:0];
        h  = ({1'b0, p[11:0]} + {1'b0, d[11:0]}) > 13'h0FFF;
        ef = {f[3], 1'b0, h, wide[16]};
      end
      4'd1, 4'd2: begin
        er = s + sx(i);
        h  = ({1'b0, s[3:0]} + {1'b0, i[3:0]}) > 5'h0F;
        cy = ({1'b0, s[7:0]} + {1'b0, i}) > 9'h0FF;
        ef = {2'b00, h, cy};
      end
      4'd3: er = d + 16'd1;
      4'd4: er = d - 16'd1;
      4'd5: er = p + 16'd1;
      4'd6: er = p - 16'd1;
      4'd7: er = 16'hFF00 + {8'h00, i};
      4'd8: er = 16'hFF00 + {8'h00, r};
      4'd9: er = c + 16'd2 + sx(i);
      default: er = 16'h0000;
    endcase
    ea = (o == 4'd5 || o == 4'd6) ? p : er;
    #2;
    case (o)
      4'd0:       begin chk("R1 result", res, er); chk("R2 flags", {12'h0, fout}, {12'h0, ef}); end
      4'd1, 4'd2: begin chk("R3 result", res, er); chk("R4 flags", {12'h0, fout}, {12'h0, ef}); end
      4'd3, 4'd4: chk("R5 result", res, er);
      4'd5, 4'd6: begin chk("R6 result", res, er); chk("R6 addr", addr, ea); end
      4'd7, 4'd8: chk("R7 result", res, er);
      4'd9:       chk("R8 result", res, er);
      default:    begin chk("R9 result", res, er); chk("R9 addr", addr, ea); end
    endcase
    if (o >= 4'd3) chk("R10 flags", {12'h0, fout}, {12'h0, ef});
    if (o != 4'd5 && o != 4'd6) chk("R11 addr", addr, ea);
  endtask

  always @(posedge clk) begin
    if (rst_n) cyc <= cyc + 1;
    if (cyc == LIMIT && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired got=%0d cycles exp<%0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    op = 4'd15; ptr = '0; sp = '0; pc = '0; opnd = '0; imm = '0; regc = '0; fin = '0;
    #20 rst_n = 1'b1;
    // R9 idle state: unused code with zero operands
    run(4'd15, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 4'hF);
    // R1 R2: pointer add over all pattern pairs, carries at 11 and 15
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run(4'd0, pats[a], 16'h1234, 16'h0, pats[b], 8'h00, 8'h00, 4'(a ^ b));
    // R3 R4: stack offset, both forms, every offset byte
    for (int a = 0; a < 16; a++)
      for (int i = 0; i < 256; i++) begin
        run(4'd1, 16'h5555, pats[a], 16'h0, 16'h0, 8'(i), 8'h00, 4'(i));
        run(4'd2, 16'hAAAA, pats[a], 16'h0, 16'h0, 8'(i), 8'h00, 4'(~i));
      end
    // R5 R6 R10: steps and post-steps, wrap at both ends
    for (int a = 0; a < 16; a++) begin
      run(4'd3, 16'h0, 16'h0, 16'h0, pats[a], 8'h00, 8'h00, 4'(a));
      run(4'd4, 16'h0, 16'h0, 16'h0, pats[a], 8'h00, 8'h00, 4'(a + 3));
      run(4'd5, pats[a], 16'h0, 16'h0, 16'h0, 8'h00, 8'h00, 4'(a + 5));
      run(4'd6, pats[a], 16'h0, 16'h0, 16'h0, 8'h00, 8'h00, 4'(a + 7));
    end
    // R7: fixed page from immediate and from register byte
    for (int i = 0; i < 256; i++) begin
      run(4'd7, 16'h0, 16'h0, 16'h0, 16'h0, 8'(i), 8'(255 - i), 4'(i));
      run(4'd8, 16'h0, 16'h0, 16'h0, 16'h0, 8'(255 - i), 8'(i), 4'(i + 1));
    end
    // R8: relative branch, forward, backward and across wrap
    for (int a = 0; a < 16; a++)
      for (int i = 0; i < 256; i++)
        run(4'd9, 16'h0, 16'h0, pats[a], 16'h0, 8'(i), 8'h00, 4'(a));
    // R9: unused codes with live operands
    for (int o = 10; o < 16; o++)
      for (int a = 0; a < 16; a++)
        run(4'(o), pats[a], pats[15 - a], pats[a], pats[a], 8'(a * 17), 8'(a), 4'(a));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule